// File: doc/BRIEF.md
# Prioritized Channel Arbiter with Fairness and Release Deadline

This block decides which device owns a shared system channel. Fifteen masters, each with a fixed priority level, compete for ownership; a sixteenth participant, the system processor, sits at the lowest level. The processor never requests. It owns the channel by default in every cycle in which no other master is eligible. A grant is either single-mode, where the owner holds the channel until it signals completion, or burst-mode, where the owner may run many transfers back to back.

When a burst owner sees an eligible competitor, the arbiter raises a release request towards it and starts a deadline counter. The counter's length is the release window divided by the clock period, and both are parameters. The owner gives up the channel either by signalling completion or when the counter expires, in which case the grant is taken from it.

A fairness rule stops the high levels from starving the low ones. Every granted master is barred from winning again. All bars clear together in the first arbitration round that finds no eligible requester, and the processor owns the channel for that round.

Top module: `chan_arbiter`

## Requirements
- R1: After reset the grant vector shows only the processor (bit 15), the owner level reads 15, and the release request is low.
- R2: The grant vector always has exactly one bit set, and the owner level equals the index of that bit (masters 0 to 14, processor 15).
- R3: In an arbitration round, the eligible master with the lowest level number wins. A master is eligible when it requests and is not barred. The new grant appears on the clock edge that ends the round.
- R4: While the processor owns the channel, an arbitration round runs in every cycle. If no master is eligible, the processor keeps ownership.
- R5: A single-mode owner keeps the grant, whatever other requests are present, until it asserts done. The grant moves on the edge that samples done.
- R6: A burst-mode owner with no eligible competitor keeps the grant indefinitely. It releases on the edge that samples done.
- R7: One cycle after an eligible competitor appears during a burst, the release request goes high. It never goes high for a single-mode owner or for the processor.
- R8: If done does not arrive, the grant is taken from the burst owner on the deadline-th clock edge after the release request rose. The deadline is the release window divided by the clock period.
- R9: A master that has been granted is barred. Its requests are ignored in later rounds until the bars clear.
- R10: A round with no eligible master grants the processor and clears every bar at once.
- R11: Outside an arbitration round the grant vector does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 15 | Request line per master, bit = level |
| burstIn | input | 15 | Burst-mode flag per master, sampled at grant |
| doneIn | input | 1 | Completion strobe from the current owner |
| grantOut | output | 16 | One-hot grant, bit 15 = processor |
| ownerLevel | output | 4 | Encoded level of the current owner |
| preemptOut | output | 1 | Release request to a bursting owner |

## Verification
The bench holds a barred high-priority master's request active while a lower level waits. A design without fairness would grant the high level again instead of the waiting one, and a design whose bars never clear would leave the processor owning the channel for good. The bench also counts edges exactly after the release request rises. A deadline counter off by one would move the grant one edge early or one edge late. Competing requests are applied under a single-mode owner as well, where a design that preempts too eagerly would raise the release request or move the grant early.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic arbitrate;   // run a round this cycle; grant updates at the edge
    logic clearBars;   // round found nobody eligible: drop every bar
  } arbStrobes_t;

endpackage

// File: rtl/chan_arb_dp.sv
module chan_arb_dp
  import chan_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 15,
  parameter int LVL_W       = $clog2(NUM_MASTERS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] burstIn,
  input  arbStrobes_t            strobes,
  output logic [NUM_MASTERS:0]   grantOut,
  output logic [LVL_W-1:0]       ownerLevel,
  output logic                   ownerIsProc,
  output logic                   ownerBurst,
  output logic                   anyEligible
);

  localparam logic [LVL_W-1:0] PROC_LVL = LVL_W'(NUM_MASTERS);

  logic [NUM_MASTERS-1:0] barMask;
  logic [NUM_MASTERS-1:0] eligible;
  logic [NUM_MASTERS-1:0] winMask;
  logic [LVL_W-1:0]       winIdx;
  logic [NUM_MASTERS:0]   grantReg;
  logic [LVL_W-1:0]       lvlReg;
  logic                   burstReg;

  assign eligible    = reqIn & ~barMask;
  assign anyEligible = |eligible;

  // Lowest level number wins: scan from the top so the lowest hit sticks
  always_comb begin
    winIdx = PROC_LVL;
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (eligible[i]) winIdx = LVL_W'(i);
    end
  end

  generate
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_winMask
      assign winMask[g] = anyEligible && (winIdx == LVL_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantReg <= (NUM_MASTERS+1)'(1) << NUM_MASTERS;
      lvlReg   <= PROC_LVL;
      burstReg <= 1'b0;
      barMask  <= '0;
    end else if (strobes.arbitrate) begin
      if (anyEligible) begin
        grantReg <= {1'b0, winMask};
        lvlReg   <= winIdx;
        burstReg <= burstIn[winIdx];
      end else begin
        grantReg <= (NUM_MASTERS+1)'(1) << NUM_MASTERS;
        lvlReg   <= PROC_LVL;
        burstReg <= 1'b0;
      end
      if (strobes.clearBars) barMask <= '0;
      else                   barMask <= barMask | winMask;
    end
  end

  assign grantOut    = grantReg;
  assign ownerLevel  = lvlReg;
  assign ownerIsProc = grantReg[NUM_MASTERS];
  assign ownerBurst  = burstReg;

  // A master that owns the channel must already be barred (fairness)
  p_owner_barred_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ownerIsProc |-> ((barMask & grantReg[NUM_MASTERS-1:0]) != '0));

  // The level register names the bit that is set in the grant
  p_level_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    grantReg[lvlReg] == 1'b1);

  // The processor never carries a burst flag
  p_proc_no_burst_r7: assert property (@(posedge clk) disable iff (!rstN)
    ownerIsProc |-> !ownerBurst);

endmodule

// File: rtl/chan_arb_ctrl.sv
module chan_arb_ctrl
  import chan_arb_pkg::*;
#(
  parameter int DEADLINE_CYC = 780,
  parameter int CNT_W        = $clog2(DEADLINE_CYC + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        doneIn,
  input  logic        ownerIsProc,
  input  logic        ownerBurst,
  input  logic        anyEligible,
  output arbStrobes_t strobes,
  output logic        preemptOut
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEADLINE_CYC - 1);

  logic             preemptReg;
  logic [CNT_W-1:0] deadlineCnt;
  logic             expired;
  logic             startPreempt;

  assign expired = preemptReg && (deadlineCnt == LAST_CNT);

  // A round runs whenever the processor holds the channel, the owner
  // reports completion, or a release deadline runs out
  assign strobes.arbitrate = ownerIsProc || doneIn || expired;
  assign strobes.clearBars = strobes.arbitrate && !anyEligible;

  assign startPreempt = !ownerIsProc && ownerBurst && anyEligible &&
                        !preemptReg && !strobes.arbitrate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preemptReg  <= 1'b0;
      deadlineCnt <= '0;
    end else if (strobes.arbitrate) begin
      preemptReg  <= 1'b0;
      deadlineCnt <= '0;
    end else if (startPreempt) begin
      preemptReg  <= 1'b1;
      deadlineCnt <= '0;
    end else if (preemptReg) begin
      deadlineCnt <= deadlineCnt + CNT_W'(1);
    end
  end

  assign preemptOut = preemptReg;

  // Release request only towards a bursting master
  p_preempt_burst_r7: assert property (@(posedge clk) disable iff (!rstN)
    preemptOut |-> (ownerBurst && !ownerIsProc));

  // The counter never runs past the deadline
  p_deadline_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    preemptOut |-> (deadlineCnt <= LAST_CNT));

  // The processor never receives a release request
  p_proc_no_preempt_r7: assert property (@(posedge clk) disable iff (!rstN)
    ownerIsProc |=> !preemptOut);

endmodule

// File: rtl/chan_arbiter.sv
module chan_arbiter
  import chan_arb_pkg::*;
#(
  parameter int NUM_MASTERS       = 15,
  parameter int CLK_PERIOD_PS     = 10000,
  parameter int RELEASE_WINDOW_PS = 7800000,
  parameter int LVL_W             = $clog2(NUM_MASTERS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] burstIn,
  input  logic                   doneIn,
  output logic [NUM_MASTERS:0]   grantOut,
  output logic [LVL_W-1:0]       ownerLevel,
  output logic                   preemptOut
);

  localparam int RAW_CYC      = RELEASE_WINDOW_PS / CLK_PERIOD_PS;
  localparam int DEADLINE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  arbStrobes_t strobes;
  logic        ownerIsProc;
  logic        ownerBurst;
  logic        anyEligible;

  chan_arb_ctrl #(.DEADLINE_CYC(DEADLINE_CYC)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .doneIn      (doneIn),
    .ownerIsProc (ownerIsProc),
    .ownerBurst  (ownerBurst),
    .anyEligible (anyEligible),
    .strobes     (strobes),
    .preemptOut  (preemptOut)
  );

  chan_arb_dp #(.NUM_MASTERS(NUM_MASTERS), .LVL_W(LVL_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqIn       (reqIn),
    .burstIn     (burstIn),
    .strobes     (strobes),
    .grantOut    (grantOut),
    .ownerLevel  (ownerLevel),
    .ownerIsProc (ownerIsProc),
    .ownerBurst  (ownerBurst),
    .anyEligible (anyEligible)
  );

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantOut) == 1);

  // A master owner with no done and no release request keeps the grant
  p_grant_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!grantOut[NUM_MASTERS] && !doneIn && !preemptOut) |=> $stable(grantOut));

endmodule

// File: tb/test_chan_arbiter.sv
module test_chan_arbiter;

  localparam int CLK_PERIOD = 10;     // ns
  localparam int NM         = 15;
  localparam int PROC       = 15;
  localparam int DEADLINE   = 780;    // 7.8 us / 10 ns

  logic          clk = 1'b0;
  logic          rstN;
  logic [NM-1:0] reqIn;
  logic [NM-1:0] burstIn;
  logic          doneIn;
  logic [NM:0]   grantOut;
  logic [3:0]    ownerLevel;
  logic          preemptOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  chan_arbiter #(
    .NUM_MASTERS(NM), .CLK_PERIOD_PS(CLK_PERIOD * 1000),
    .RELEASE_WINDOW_PS(7800000)
  ) i_chan_arbiter (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .burstIn(burstIn),
    .doneIn(doneIn), .grantOut(grantOut), .ownerLevel(ownerLevel),
    .preemptOut(preemptOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic checkOwner(input int exp, input string tag);
    checks++;
    if (grantOut != ((NM+1)'(1) << exp) || ownerLevel != 4'(exp)) begin
      errors++;
      $display("FAIL %s: grant=%h level=%0d expected grant=%h level=%0d",
               tag, grantOut, ownerLevel, (NM+1)'(1) << exp, exp);
    end
  endtask

  task automatic checkPreempt(input logic exp, input string tag);
    checks++;
    if (preemptOut !== exp) begin
      errors++;
      $display("FAIL %s: preempt=%b expected %b", tag, preemptOut, exp);
    end
  endtask

  task automatic pulseDone();
    doneIn = 1'b1;
    step();
    doneIn = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0; reqIn = '0; burstIn = '0; doneIn = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
    checkOwner(PROC, "R1 reset owner");
    checkPreempt(1'b0, "R1 reset preempt");
  endtask

  task automatic testPriority();
    reqIn[3] = 1'b1; reqIn[7] = 1'b1;
    step();
    checkOwner(3, "R3 lowest level wins");
    for (int i = 0; i < 3; i++) step();
    checkOwner(3, "R5 single owner holds without done");
    checkPreempt(1'b0, "R7 no preempt in single mode");
    reqIn[3] = 1'b0;
    pulseDone();
    checkOwner(7, "R5 grant moves on done");
    reqIn[7] = 1'b0;
    step();
    checkOwner(7, "R11 grant stable between rounds");
    pulseDone();
    checkOwner(PROC, "R4 processor takes idle channel");
    step();
    checkOwner(PROC, "R4 processor keeps idle channel");
  endtask

  task automatic testFairness();
    reqIn[2] = 1'b1; reqIn[5] = 1'b1;
    step();
    checkOwner(2, "R3 level 2 first");
    pulseDone();
    checkOwner(5, "R9 barred level 2 ignored");
    pulseDone();
    checkOwner(PROC, "R10 no eligible gives processor");
    step();
    checkOwner(2, "R10 bars cleared, level 2 wins again");
    reqIn = '0;
    pulseDone();
    checkOwner(PROC, "R4 back to processor");
    step();
  endtask

  task automatic testBurstDone();
    reqIn[4] = 1'b1; burstIn[4] = 1'b1;
    step();
    checkOwner(4, "R6 burst grant");
    reqIn[4] = 1'b0;
    for (int i = 0; i < 10; i++) step();
    checkOwner(4, "R6 burst owner holds alone");
    checkPreempt(1'b0, "R7 no preempt without competitor");
    reqIn[1] = 1'b1;
    step();
    checkPreempt(1'b1, "R7 preempt after competitor");
    checkOwner(4, "R11 owner kept while preempted");
    pulseDone();
    checkOwner(1, "R6 burst releases on done");
    checkPreempt(1'b0, "R7 preempt drops on release");
    reqIn = '0; burstIn = '0;
    pulseDone();
    checkOwner(PROC, "R4 processor after single");
    step();
  endtask

  task automatic testDeadline();
    reqIn[8] = 1'b1; burstIn[8] = 1'b1;
    step();
    checkOwner(8, "R6 burst grant level 8");
    reqIn[8] = 1'b0; burstIn[8] = 1'b0; reqIn[9] = 1'b1;
    step();
    checkPreempt(1'b1, "R7 preempt raised");
    for (int i = 0; i < DEADLINE - 1; i++) step();
    checkOwner(8, "R8 owner kept until deadline edge");
    step();
    checkOwner(9, "R8 grant forced away at deadline");
    checkPreempt(1'b0, "R8 preempt cleared");
    reqIn = '0;
    pulseDone();
    checkOwner(PROC, "R4 processor at end");
  endtask

  initial begin
    fork
      begin
        testReset();
        testPriority();
        testFairness();
        testBurstDone();
        testDeadline();
      end
      begin
        wait (cycles > 100000);
        checks++; errors++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule